// File: doc/BRIEF.md
# Class-Weighted Probabilistic Confidence Counter Bank

This block holds a bank of small saturating confidence counters for a value predictor. Each update names one counter and reports whether the prediction tied to it was right. A correct result raises the counter by one. It does so only with a probability picked by a class code that describes the instruction's type and latency. Expensive instructions, such as a load that misses the last cache level, gain confidence at once. Cheap ones, such as a single-cycle ALU operation, gain it rarely. The random draw comes from an internal linear-feedback shift register.

A wrong result either lowers the counter by a fixed step or clears it. The choice depends on whether the prediction was in use at high confidence. A prediction that was trusted and fails once is therefore not thrown away: the counter keeps some of its history. A read port returns the count of any entry and shows whether it is at or above the high-confidence level. The predictor tables that own these counters sit outside this block.

Top module: `conf_prob_counter`

## Requirements
- R1: After reset every counter reads 0 and the LFSR holds the seed 16'hACE1.
- R2: An accepted update with `upd_hit`=1 raises the addressed counter by one when the draw fires. The counter stops at 31 and never wraps.
- R3: The class code picks k, and the increment probability is 1/2^k. The codes map as follows: 0 = last-level-miss load, k=0. 1 = last-level-hit load, k=2. 2 = mid-level-hit load, k=4. 3 = first-level-hit load, k=6. 4 = slow ALU or floating point, k=5. 5 = single-cycle ALU, k=7. 6 = large stride, k=1. 7 = small stride, k=3.
- R4: The draw fires when the low k bits of the LFSR, as it stands before the update, are all zero. The LFSR shifts left by one on every accepted update, hit or miss. The new bit 0 is bit15 XOR bit13 XOR bit12 XOR bit10.
- R5: On an accepted update with `upd_hit`=0 and `upd_was_hi`=1, the addressed counter drops by 4 and stops at 0.
- R6: On an accepted update with `upd_hit`=0 and `upd_was_hi`=0, the addressed counter is cleared to 0.
- R7: `rd_cnt` shows the entry chosen by `rd_idx` with no added latency. `rd_hi` is 1 exactly when that count is 7 or more. An update shows on the read port in the cycle after its clock edge.
- R8: While `upd_valid` is 0, all other update inputs are ignored: no counter changes and the LFSR does not advance.
- R9: An update changes only the entry named by `upd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Update strobe |
| upd_idx | input | 4 | Entry to update |
| upd_hit | input | 1 | 1 = prediction was correct |
| upd_class | input | 3 | Instruction class code (R3) |
| upd_was_hi | input | 1 | Prediction was at high confidence |
| rd_idx | input | 4 | Entry to read |
| rd_cnt | output | 5 | Count of the entry being read |
| rd_hi | output | 1 | Count of the entry being read is 7 or more |

## Verification
The assertions assume that `upd_idx` and `rd_idx` always name an existing entry. They also assume the update inputs are defined whenever `upd_valid` is high. Checks on a counter's next value compare it with its previous value only when `rd_idx` has not changed across the edge, so they let the read address move freely. The stimulus draws indices from the full power-of-two range, holds all inputs steady for a whole cycle, and drives every field to a known value even while the strobe is low.

// File: rtl/conf_prob_pkg.sv
package conf_prob_pkg;

  localparam int CLS_W = 3;
  localparam logic [15:0] LFSR16_TAPS = 16'hB400;

  typedef enum logic [CLS_W-1:0] {
    CLS_LLC_MISS   = 3'd0,
    CLS_LLC_HIT    = 3'd1,
    CLS_MID_HIT    = 3'd2,
    CLS_NEAR_HIT   = 3'd3,
    CLS_SLOW_ALU   = 3'd4,
    CLS_FAST_ALU   = 3'd5,
    CLS_BIG_STRIDE = 3'd6,
    CLS_SML_STRIDE = 3'd7
  } cls_e;

  // log2 of the inverse increment probability for each class
  function automatic int unsigned cls_shift(input logic [CLS_W-1:0] c);
    case (cls_e'(c))
      CLS_LLC_MISS:   return 0;
      CLS_LLC_HIT:    return 2;
      CLS_MID_HIT:    return 4;
      CLS_NEAR_HIT:   return 6;
      CLS_SLOW_ALU:   return 5;
      CLS_FAST_ALU:   return 7;
      CLS_BIG_STRIDE: return 1;
      default:        return 3;
    endcase
  endfunction

  function automatic int unsigned sat_up(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  function automatic int unsigned sat_down(input int unsigned v, input int unsigned step);
    return (v > step) ? v - step : 0;
  endfunction

endpackage

// File: rtl/conf_lfsr.sv
module conf_lfsr #(
  parameter int W = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= {state[W-2:0], fb};
  end
endmodule

// File: rtl/conf_class_gate.sv
module conf_class_gate
  import conf_prob_pkg::*;
#(
  parameter int LFSR_W = 16
) (
  input  logic [LFSR_W-1:0] rnd,
  input  logic [CLS_W-1:0]  cls,
  output logic              fire
);
  logic [LFSR_W-1:0] mask;
  always_comb begin
    mask = LFSR_W'((32'd1 << cls_shift(cls)) - 32'd1);
    fire = ((rnd & mask) == '0);
  end
endmodule

// File: rtl/conf_cnt_bank.sv
module conf_cnt_bank
  import conf_prob_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int CNT_W    = 5,
  parameter int DEC_STEP = 4,
  parameter int IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             inc_fire,
  input  logic             dec_fire,
  input  logic             clr_fire,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_cnt
);
  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_q [ENTRIES];
  logic [CNT_W-1:0] cur_val;
  logic [CNT_W-1:0] nxt_val;
  logic             any_wr;

  assign cur_val = cnt_q[wr_idx];
  assign any_wr  = inc_fire | dec_fire | clr_fire;

  always_comb begin
    if (inc_fire)      nxt_val = CNT_W'(sat_up(int'(cur_val), CNT_MAX));
    else if (dec_fire) nxt_val = CNT_W'(sat_down(int'(cur_val), DEC_STEP));
    else               nxt_val = '0;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                                 cnt_q[e] <= '0;
      else if (any_wr && wr_idx == IDX_W'(e))     cnt_q[e] <= nxt_val;
    end
  end

  assign rd_cnt = cnt_q[rd_idx];
endmodule

// File: rtl/conf_prob_counter.sv
module conf_prob_counter
  import conf_prob_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int CNT_W    = 5,
  parameter int HI_LEVEL = 7,
  parameter int DEC_STEP = 4,
  parameter int LFSR_W   = 16,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  parameter int IDX_W    = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_hit,
  input  logic [CLS_W-1:0] upd_class,
  input  logic             upd_was_hi,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_cnt,
  output logic             rd_hi
);
  logic [LFSR_W-1:0] lfsr_q;
  logic              draw_fire;
  logic              inc_fire;
  logic              dec_fire;
  logic              clr_fire;

  conf_lfsr #(.W(LFSR_W), .SEED(SEED), .TAPS(LFSR_W'(LFSR16_TAPS))) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(upd_valid), .state(lfsr_q)
  );

  conf_class_gate #(.LFSR_W(LFSR_W)) u_gate (
    .rnd(lfsr_q), .cls(upd_class), .fire(draw_fire)
  );

  assign inc_fire = upd_valid & upd_hit & draw_fire;
  assign dec_fire = upd_valid & ~upd_hit & upd_was_hi;
  assign clr_fire = upd_valid & ~upd_hit & ~upd_was_hi;

  conf_cnt_bank #(.ENTRIES(ENTRIES), .CNT_W(CNT_W), .DEC_STEP(DEC_STEP), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_idx(upd_idx),
    .inc_fire(inc_fire), .dec_fire(dec_fire), .clr_fire(clr_fire),
    .rd_idx(rd_idx), .rd_cnt(rd_cnt)
  );

  assign rd_hi = (rd_cnt >= CNT_W'(HI_LEVEL));
endmodule

// File: rtl/conf_prob_counter_chk.sv
module conf_prob_counter_chk #(
  parameter int CNT_W  = 5,
  parameter int LFSR_W = 16,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_valid,
  input logic              upd_hit,
  input logic [2:0]        upd_class,
  input logic [IDX_W-1:0]  upd_idx,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [CNT_W-1:0]  rd_cnt,
  input logic [LFSR_W-1:0] lfsr_q,
  input logic              inc_fire,
  input logic              dec_fire,
  input logic              clr_fire
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  // R4
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  // R8
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(lfsr_q));

  // R3
  llc_miss_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_hit && upd_class == 3'd0) |-> inc_fire);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> (rd_idx != $past(rd_idx) || rd_cnt == $past(rd_cnt)));

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_fire && rd_idx == upd_idx && rd_cnt != MAXV)
      |=> (rd_idx != $past(rd_idx) || rd_cnt == $past(rd_cnt) + 1'b1));

  // R2
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_fire && rd_idx == upd_idx && rd_cnt == MAXV)
      |=> (rd_idx != $past(rd_idx) || rd_cnt == MAXV));

  // R5
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_fire && rd_idx == upd_idx)
      |=> (rd_idx != $past(rd_idx) ||
           rd_cnt == (($past(rd_cnt) > 4) ? $past(rd_cnt) - 3'd4 : '0)));

  // R6
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fire && rd_idx == upd_idx) |=> (rd_idx != $past(rd_idx) || rd_cnt == '0));

  // R2
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inc_fire, dec_fire, clr_fire}));
endmodule

bind conf_prob_counter conf_prob_counter_chk #(.CNT_W(CNT_W), .LFSR_W(LFSR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_hit(upd_hit),
  .upd_class(upd_class), .upd_idx(upd_idx), .rd_idx(rd_idx), .rd_cnt(rd_cnt),
  .lfsr_q(lfsr_q), .inc_fire(inc_fire), .dec_fire(dec_fire), .clr_fire(clr_fire)
);

// File: tb/sim_conf_prob_counter.sv
`timescale 1ns/1ps
module sim_conf_prob_counter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       upd_valid, upd_hit, upd_was_hi;
  logic [3:0] upd_idx, rd_idx;
  logic [2:0] upd_class;
  logic [4:0] rd_cnt;
  logic       rd_hi;

  always #5 clk = ~clk;

  conf_prob_counter u0 (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_idx(upd_idx),
    .upd_hit(upd_hit), .upd_class(upd_class), .upd_was_hi(upd_was_hi),
    .rd_idx(rd_idx), .rd_cnt(rd_cnt), .rd_hi(rd_hi)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;
  int    model [16];
  bit [15:0] m_rng;

  function automatic int bench_k(input int c);
    int tbl [8] = '{0, 2, 4, 6, 5, 7, 1, 3};
    return tbl[c];
  endfunction

  function automatic bit [15:0] rng_next(input bit [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic check_entry(input int idx, input string tag);
    rd_idx = 4'(idx);
    #1;
    n_chk++;
    if (rd_cnt !== 5'(model[idx]) || rd_hi !== (model[idx] >= 7)) begin
      n_bad++;
      $display("FAIL %s: entry %0d cnt=%0d exp=%0d hi=%0b exp=%0b",
               tag, idx, rd_cnt, model[idx], rd_hi, model[idx] >= 7);
    end
  endtask

  task automatic do_upd(input int idx, input bit hit, input int cls, input bit was_hi,
                        input string tag);
    int k;
    @(negedge clk);
    upd_valid = 1; upd_idx = 4'(idx); upd_hit = hit;
    upd_class = 3'(cls); upd_was_hi = was_hi;
    k = bench_k(cls);
    if (hit) begin
      if ((m_rng % (17'd1 << k)) == 0 && model[idx] < 31) model[idx]++;
    end else if (was_hi) model[idx] = (model[idx] > 4) ? model[idx] - 4 : 0;
    else model[idx] = 0;
    m_rng = rng_next(m_rng);
    @(negedge clk);
    upd_valid = 0;
    check_entry(idx, tag);
  endtask

  task automatic idle_noise(input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      upd_valid = 0; upd_idx = 4'($urandom); upd_hit = 1'($urandom);
      upd_class = 3'($urandom); upd_was_hi = 1'($urandom);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; upd_valid = 0; upd_idx = 0; upd_hit = 0; upd_class = 0;
    upd_was_hi = 0; rd_idx = 0;
    for (int i = 0; i < 16; i++) model[i] = 0;
    m_rng = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) check_entry(i, "R1 reset");

    // last-level miss: always increments, saturates, crosses threshold
    for (int n = 0; n < 34; n++) do_upd(3, 1, 0, 0, "R2 R7 certain increment");
    check_entry(3, "R2 saturate at 31");

    // hysteretic decrement down to floor
    for (int n = 0; n < 9; n++) do_upd(3, 0, 0, 1, "R5 decrement by 4");

    // rebuild then clear
    for (int n = 0; n < 5; n++) do_upd(3, 1, 0, 0, "R2 rebuild");
    do_upd(3, 0, 2, 0, "R6 clear on low-confidence miss");

    // ignored inputs while strobe low
    idle_noise(20);
    for (int i = 0; i < 16; i++) check_entry(i, "R8 idle no change");

    // rare class on one entry, LFSR alignment after idle
    for (int n = 0; n < 400; n++) do_upd(7, 1, 5, 0, "R3 R4 single-cycle ALU rate");
    for (int i = 0; i < 16; i++) check_entry(i, "R9 others untouched");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int idx, cls; bit hit, wh;
      idx = int'($urandom % 16); cls = int'($urandom % 8);
      hit = ($urandom % 8) != 0; wh = 1'($urandom);
      do_upd(idx, hit, cls, wh, "R3 R4 random");
      if (($urandom % 16) == 0) idle_noise(int'($urandom % 4) + 1);
      if (n % 500 == 499)
        for (int i = 0; i < 16; i++) check_entry(i, "R9 scan");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule